// File: doc/BRIEF.md
# Wavefront Scalar Register Initializer

When a wavefront is launched, its scalar register file must be seeded with setup values before the first instruction runs. This block takes a 32-bit resource descriptor word, up to 31 user data words, the three workgroup ids, the workgroup size value, the scratch wave offset, the number of allocated scalar registers and a generation select. From these it works out a packed layout of the leading registers and streams one write per cycle into the scalar file through a valid/ready port.

The leading registers hold the user data, then one workgroup id per enabled dimension, then the optional size word, then the optional scratch offset. The block does not write the special register pairs at the top of the allocation. It reports the index where each pair begins, and that set of pairs depends on the generation. If the leading registers would run into the reserved top pairs, or the allocation exceeds the generation's limit, the block flags an error and writes nothing. In every case it ends with a one-cycle done pulse.

Top module: `sgpr_launch_init`

## Requirements
- R1: The user data count is resource bits [5:1] (0 to 31). User data word i is written to register i for every i below that count.
- R2: Right after the user data come one register per enabled dimension, in the order X, Y, Z. The enables are resource bit 7 (X), bit 8 (Y) and bit 9 (Z). A disabled dimension takes no register.
- R3: Next comes the workgroup size word, written only when resource bit 10 is set. After it comes the scratch wave offset, written only when resource bit 0 is set.
- R4: Writes start at register 0 and go up by one per accepted write. Exactly the leading registers are written, and no write targets the reserved top pairs.
- R5: While wr_valid_o is high and wr_ready_i is low, the write index and data stay unchanged until the write is accepted.
- R6: vcc_idx_o reports N-2, where N is the allocated register count latched at start.
- R7: gen_i encoding: 0 is the oldest generation, which reserves no extra pair (both valid flags low). 1 is the middle generation: flat scratch pair at N-4. 2 and 3 are the newest generation: flat scratch pair at N-6 and translation-failure mask pair at N-4.
- R8: An allocation above 104 (gen 0 and 1) or above 102 (gen 2 and 3) raises alloc_err_o and issues no writes.
- R9: If the leading register count exceeds the first reserved index (N-2, N-4 or N-6 by generation), alloc_err_o is raised and no write is issued. alloc_err_o holds until the next accepted start.
- R10: A start pulse while busy_o is high is ignored: neither the write stream nor the reported indices change.
- R11: done_o is high for exactly one cycle. It follows the acceptance of the last write, or follows the start directly when there is nothing to write or the layout is in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Launch pulse |
| rsrc_i | input | 32 | Resource descriptor word |
| user_data_i | input | 992 | 31 user data words, word i in bits [32i+31:32i] |
| gid_x_i | input | 32 | Workgroup id X |
| gid_y_i | input | 32 | Workgroup id Y |
| gid_z_i | input | 32 | Workgroup id Z |
| wg_size_i | input | 32 | Workgroup size value |
| scratch_ofs_i | input | 32 | Scratch wave offset |
| alloc_n_i | input | 7 | Number of allocated scalar registers |
| gen_i | input | 2 | Generation select |
| wr_valid_o | output | 1 | Register write valid |
| wr_ready_i | input | 1 | Register file accepts write |
| wr_idx_o | output | 7 | Register write index |
| wr_data_o | output | 32 | Register write data |
| vcc_idx_o | output | 7 | First register of the condition code pair |
| flat_idx_o | output | 7 | First register of the flat scratch pair |
| flat_vld_o | output | 1 | Flat scratch pair reserved |
| xnack_idx_o | output | 7 | First register of the translation-failure mask pair |
| xnack_vld_o | output | 1 | Translation-failure mask pair reserved |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle completion pulse |
| alloc_err_o | output | 1 | Layout did not fit the allocation |

## Verification
The layout walk is tried with all three dimensions enabled, with only Y, and with X and Z but not Y. These patterns show whether a skipped dimension really gives up its slot or leaves a gap. The full 36-register leading block is placed in the oldest generation so that it fills the space exactly, and then in the newest generation, where it collides with the reserved pairs. Together these cases separate an off-by-one in the overlap test from a correct one. Allocation counts of 103, 104 and 105 probe the limit for each generation, and an empty layout checks that done still pulses. A stalling ready pattern and a second start while busy test that the stream holds its write and ignores the extra start.

// File: rtl/sgpr_init_pkg.sv
package sgpr_init_pkg;

  localparam int DATA_W        = 32;
  localparam int IDX_W         = 7;
  localparam int UCNT_W        = 5;
  localparam int USER_SLOTS    = (1 << UCNT_W) - 1;
  localparam int ALLOC_MAX_OLD = 104;
  localparam int ALLOC_MAX_NEW = 102;
  localparam int RSRC_SCR_BIT  = 0;
  localparam int RSRC_UCNT_LSB = 1;
  localparam int RSRC_GID_LSB  = 7;
  localparam int RSRC_SIZE_BIT = 10;

  typedef enum logic [1:0] {
    GEN_OLD  = 2'd0,
    GEN_MID  = 2'd1,
    GEN_NEW  = 2'd2,
    GEN_NEW2 = 2'd3
  } gen_e;

  typedef enum logic [2:0] {
    SRC_USER, SRC_GID_X, SRC_GID_Y, SRC_GID_Z, SRC_SIZE, SRC_SCR
  } src_e;

  typedef enum logic [1:0] {
    ST_IDLE, ST_WRITE, ST_FIN
  } seq_state_e;

  typedef struct packed {
    logic [UCNT_W-1:0] ucnt;
    logic [2:0]        gid_en;
    logic              size_en;
    logic              scr_en;
  } enables_t;

  typedef struct packed {
    logic [IDX_W-1:0] lead;
    logic [IDX_W-1:0] resv;
    logic [IDX_W-1:0] vcc;
    logic [IDX_W-1:0] flat;
    logic [IDX_W-1:0] xnack;
    logic             flat_vld;
    logic             xnack_vld;
    logic             err;
  } layout_t;

  function automatic enables_t decode_rsrc(input logic [31:0] w);
    enables_t e;
    e.ucnt    = w[RSRC_UCNT_LSB +: UCNT_W];
    e.gid_en  = w[RSRC_GID_LSB +: 3];
    e.size_en = w[RSRC_SIZE_BIT];
    e.scr_en  = w[RSRC_SCR_BIT];
    return e;
  endfunction

  // Registers reserved at the top of the allocation, per generation.
  function automatic int trail_regs(input gen_e g);
    case (g)
      GEN_OLD: return 2;
      GEN_MID: return 4;
      default: return 6;
    endcase
  endfunction

  function automatic int alloc_limit(input gen_e g);
    if (g == GEN_OLD || g == GEN_MID) return ALLOC_MAX_OLD;
    return ALLOC_MAX_NEW;
  endfunction

  function automatic int lead_regs(input enables_t e);
    return int'(e.ucnt) + int'(e.gid_en[0]) + int'(e.gid_en[1]) +
           int'(e.gid_en[2]) + int'(e.size_en) + int'(e.scr_en);
  endfunction

  // Walks the enable bits to find which source feeds register idx.
  function automatic src_e slot_source(input int idx, input enables_t e);
    int r;
    r = idx - int'(e.ucnt);
    if (r < 0) return SRC_USER;
    for (int d = 0; d < 3; d++) begin
      if (e.gid_en[d]) begin
        if (r == 0) return (d == 0) ? SRC_GID_X : (d == 1) ? SRC_GID_Y : SRC_GID_Z;
        r = r - 1;
      end
    end
    if (e.size_en) begin
      if (r == 0) return SRC_SIZE;
      r = r - 1;
    end
    return SRC_SCR;
  endfunction

endpackage

// File: rtl/sgpr_layout_calc.sv
module sgpr_layout_calc
  import sgpr_init_pkg::*;
(
  input  enables_t               en,
  input  logic [IDX_W-1:0]       alloc_n,
  input  logic [1:0]             gen,
  output layout_t                lay
);

  gen_e g;
  int   n;
  int   trail;
  int   base;
  int   lead;

  always_comb begin
    g     = gen_e'(gen);
    n     = int'(alloc_n);
    trail = trail_regs(g);
    base  = n - trail;
    lead  = lead_regs(en);
    lay   = '0;
    lay.err  = (n > alloc_limit(g)) || (base < 0) || (lead > base);
    lay.lead = IDX_W'(lead);
    lay.resv = (base < 0) ? '0 : IDX_W'(base);
    lay.vcc  = IDX_W'(n - 2);
    if (g != GEN_OLD) begin
      lay.flat_vld = 1'b1;
      lay.flat     = IDX_W'(n - trail);
    end
    if (g == GEN_NEW || g == GEN_NEW2) begin
      lay.xnack_vld = 1'b1;
      lay.xnack     = IDX_W'(n - 4);
    end
  end

endmodule

// File: rtl/sgpr_slot_mux.sv
module sgpr_slot_mux
  import sgpr_init_pkg::*;
(
  input  logic [IDX_W-1:0]             idx,
  input  enables_t                     en,
  input  logic [USER_SLOTS*DATA_W-1:0] user_data,
  input  logic [DATA_W-1:0]            gid_x,
  input  logic [DATA_W-1:0]            gid_y,
  input  logic [DATA_W-1:0]            gid_z,
  input  logic [DATA_W-1:0]            wg_size,
  input  logic [DATA_W-1:0]            scratch_ofs,
  output logic [DATA_W-1:0]            data
);

  localparam int PAD_W = (USER_SLOTS + 1) * DATA_W;

  logic [PAD_W-1:0]  user_pad;
  logic [UCNT_W-1:0] user_sel;
  src_e              src;

  assign user_pad = {{DATA_W{1'b0}}, user_data};
  assign user_sel = idx[UCNT_W-1:0];
  assign src      = slot_source(int'(idx), en);

  always_comb begin
    case (src)
      SRC_USER:  data = user_pad[int'(user_sel)*DATA_W +: DATA_W];
      SRC_GID_X: data = gid_x;
      SRC_GID_Y: data = gid_y;
      SRC_GID_Z: data = gid_z;
      SRC_SIZE:  data = wg_size;
      default:   data = scratch_ofs;
    endcase
  end

endmodule

// File: rtl/sgpr_seq_fsm.sv
module sgpr_seq_fsm
  import sgpr_init_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             err_now,
  input  logic [IDX_W-1:0] lead_now,
  input  logic [IDX_W-1:0] lead_q,
  input  logic             wr_ready,
  output logic             load,
  output logic             wr_valid,
  output logic [IDX_W-1:0] wr_idx,
  output logic             last_beat,
  output logic             busy,
  output logic             done
);

  seq_state_e       state;
  logic [IDX_W-1:0] cnt;
  logic             accept;

  assign load      = (state == ST_IDLE) && start;
  assign wr_valid  = (state == ST_WRITE);
  assign wr_idx    = cnt;
  assign accept    = wr_valid && wr_ready;
  assign last_beat = wr_valid && (cnt == lead_q - IDX_W'(1));
  assign busy      = (state != ST_IDLE);
  assign done      = (state == ST_FIN);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load) begin
            cnt   <= '0;
            state <= (err_now || lead_now == '0) ? ST_FIN : ST_WRITE;
          end
        end
        ST_WRITE: begin
          if (accept) begin
            if (last_beat) state <= ST_FIN;
            else           cnt   <= cnt + IDX_W'(1);
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/sgpr_launch_init.sv
module sgpr_launch_init
  import sgpr_init_pkg::*;
(
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         start_i,
  input  logic [31:0]                  rsrc_i,
  input  logic [USER_SLOTS*DATA_W-1:0] user_data_i,
  input  logic [DATA_W-1:0]            gid_x_i,
  input  logic [DATA_W-1:0]            gid_y_i,
  input  logic [DATA_W-1:0]            gid_z_i,
  input  logic [DATA_W-1:0]            wg_size_i,
  input  logic [DATA_W-1:0]            scratch_ofs_i,
  input  logic [IDX_W-1:0]             alloc_n_i,
  input  logic [1:0]                   gen_i,
  output logic                         wr_valid_o,
  input  logic                         wr_ready_i,
  output logic [IDX_W-1:0]             wr_idx_o,
  output logic [DATA_W-1:0]            wr_data_o,
  output logic [IDX_W-1:0]             vcc_idx_o,
  output logic [IDX_W-1:0]             flat_idx_o,
  output logic                         flat_vld_o,
  output logic [IDX_W-1:0]             xnack_idx_o,
  output logic                         xnack_vld_o,
  output logic                         busy_o,
  output logic                         done_o,
  output logic                         alloc_err_o
);

  enables_t                     en_d, en_q;
  layout_t                      lay_d, lay_q;
  logic [USER_SLOTS*DATA_W-1:0] user_q;
  logic [DATA_W-1:0]            gx_q, gy_q, gz_q, size_q, scr_q;
  logic                         err_q;

  // Named internal events for the checker.
  logic                         load;
  logic                         last_beat;
  logic [IDX_W-1:0]             resv_base;

  assign en_d = decode_rsrc(rsrc_i);

  sgpr_layout_calc u_layout (
    .en      (en_d),
    .alloc_n (alloc_n_i),
    .gen     (gen_i),
    .lay     (lay_d)
  );

  sgpr_seq_fsm u_fsm (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start_i),
    .err_now   (lay_d.err),
    .lead_now  (lay_d.lead),
    .lead_q    (lay_q.lead),
    .wr_ready  (wr_ready_i),
    .load      (load),
    .wr_valid  (wr_valid_o),
    .wr_idx    (wr_idx_o),
    .last_beat (last_beat),
    .busy      (busy_o),
    .done      (done_o)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      lay_q  <= '0;
      user_q <= '0;
      gx_q   <= '0;
      gy_q   <= '0;
      gz_q   <= '0;
      size_q <= '0;
      scr_q  <= '0;
      err_q  <= 1'b0;
    end else if (load) begin
      en_q   <= en_d;
      lay_q  <= lay_d;
      user_q <= user_data_i;
      gx_q   <= gid_x_i;
      gy_q   <= gid_y_i;
      gz_q   <= gid_z_i;
      size_q <= wg_size_i;
      scr_q  <= scratch_ofs_i;
      err_q  <= lay_d.err;
    end
  end

  sgpr_slot_mux u_mux (
    .idx         (wr_idx_o),
    .en          (en_q),
    .user_data   (user_q),
    .gid_x       (gx_q),
    .gid_y       (gy_q),
    .gid_z       (gz_q),
    .wg_size     (size_q),
    .scratch_ofs (scr_q),
    .data        (wr_data_o)
  );

  assign resv_base   = lay_q.resv;
  assign vcc_idx_o   = lay_q.vcc;
  assign flat_idx_o  = lay_q.flat;
  assign flat_vld_o  = lay_q.flat_vld;
  assign xnack_idx_o = lay_q.xnack;
  assign xnack_vld_o = lay_q.xnack_vld;
  assign alloc_err_o = err_q;

endmodule

// File: rtl/sgpr_init_checker.sv
module sgpr_init_checker
  import sgpr_init_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             start,
  input logic             wr_valid,
  input logic             wr_ready,
  input logic [IDX_W-1:0] wr_idx,
  input logic [DATA_W-1:0] wr_data,
  input logic             last_beat,
  input logic [IDX_W-1:0] resv_base,
  input logic [IDX_W-1:0] vcc_idx,
  input logic [IDX_W-1:0] flat_idx,
  input logic             busy,
  input logic             done,
  input logic             alloc_err
);

  assert_ascending_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && !last_beat) |=> (wr_valid && wr_idx == $past(wr_idx) + IDX_W'(1)));

  assert_first_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !$past(busy)) |-> (wr_idx == '0));

  assert_below_reserved_R9: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid |-> (wr_idx < resv_base));

  assert_stall_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_idx) && $stable(wr_data)));

  assert_err_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    alloc_err |-> !wr_valid);

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_done_after_last_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_ready && last_beat) |=> done);

  assert_busy_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start) |=> ($stable(vcc_idx) && $stable(flat_idx)));

endmodule

bind sgpr_launch_init sgpr_init_checker u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .start     (start_i),
  .wr_valid  (wr_valid_o),
  .wr_ready  (wr_ready_i),
  .wr_idx    (wr_idx_o),
  .wr_data   (wr_data_o),
  .last_beat (last_beat),
  .resv_base (resv_base),
  .vcc_idx   (vcc_idx_o),
  .flat_idx  (flat_idx_o),
  .busy      (busy_o),
  .done      (done_o),
  .alloc_err (alloc_err_o)
);

// File: tb/test_sgpr_launch_init.sv
module test_sgpr_launch_init;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic [31:0]   rsrc_i = '0;
  logic [991:0]  user_data_i = '0;
  logic [31:0]   gid_x_i = '0, gid_y_i = '0, gid_z_i = '0, wg_size_i = '0, scratch_ofs_i = '0;
  logic [6:0]    alloc_n_i = '0;
  logic [1:0]    gen_i = '0;
  logic          wr_ready_i = 1'b1;
  logic          wr_valid_o, flat_vld_o, xnack_vld_o, busy_o, done_o, alloc_err_o;
  logic [6:0]    wr_idx_o, vcc_idx_o, flat_idx_o, xnack_idx_o;
  logic [31:0]   wr_data_o;

  int n_chk = 0;
  int n_fail = 0;
  int cyc = 0;
  bit stall_mode = 1'b0;

  logic [6:0]  q_idx[$];
  logic [31:0] q_dat[$];

  sgpr_launch_init i_sgpr_launch_init (.*);

  always #5 clk = ~clk;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  // Watchdog
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 50000) begin
        n_chk++; n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 50000);
        summary();
      end
    end
  end

  // Ready driver: stalls one cycle in three when stall_mode is set.
  initial begin
    int k = 0;
    forever begin
      @(posedge clk); #1;
      k++;
      wr_ready_i = stall_mode ? (k % 3 != 1) : 1'b1;
    end
  end

  // Monitor: pops expected writes, checks stall stability (R5).
  initial begin
    bit         prev_stall = 1'b0;
    logic [6:0] p_idx = '0;
    logic [31:0] p_dat = '0;
    forever begin
      @(negedge clk);
      if (rst_n) begin
        if (prev_stall) begin
          chk(wr_valid_o, "R5", "valid held", 32'(wr_valid_o), 1);
          chk(wr_idx_o == p_idx, "R5", "idx held", 32'(wr_idx_o), 32'(p_idx));
          chk(wr_data_o == p_dat, "R5", "data held", wr_data_o, p_dat);
        end
        prev_stall = wr_valid_o && !wr_ready_i;
        p_idx = wr_idx_o;
        p_dat = wr_data_o;
        if (wr_valid_o && wr_ready_i) begin
          if (q_idx.size() == 0) begin
            chk(1'b0, "R4", "unexpected write idx", 32'(wr_idx_o), 0);
          end else begin
            logic [6:0]  ei;
            logic [31:0] ed;
            ei = q_idx.pop_front();
            ed = q_dat.pop_front();
            chk(wr_idx_o == ei, "R4", "write idx", 32'(wr_idx_o), 32'(ei));
            chk(wr_data_o == ed, "R1 R2 R3", "write data", wr_data_o, ed);
          end
        end
      end
    end
  end

  task automatic push(inout int k, input logic [31:0] d);
    q_idx.push_back(7'(k));
    q_dat.push_back(d);
    k++;
  endtask

  task automatic run_case(input int ucnt, input bit [2:0] gid, input bit sz, input bit scr,
                          input int n, input int gen, input int seed, input bit poke);
    int pairs, maxn, lead, k, w;
    bit exp_err;
    pairs   = (gen == 0) ? 1 : (gen == 1) ? 2 : 3;
    maxn    = (gen >= 2) ? 102 : 104;
    lead    = ucnt + gid[0] + gid[1] + gid[2] + sz + scr;
    exp_err = (n > maxn) || (lead > n - 2 * pairs);

    @(posedge clk); #1;
    for (int i = 0; i < 31; i++) user_data_i[i*32 +: 32] = 32'(seed * 4096 + i * 17 + 1);
    gid_x_i = 32'(seed + 32'h1000); gid_y_i = 32'(seed + 32'h2000);
    gid_z_i = 32'(seed + 32'h3000); wg_size_i = 32'(seed + 32'h4000);
    scratch_ofs_i = 32'(seed + 32'h5000);
    rsrc_i = '0;
    rsrc_i[5:1] = 5'(ucnt);
    rsrc_i[9:7] = gid;
    rsrc_i[10]  = sz;
    rsrc_i[0]   = scr;
    alloc_n_i = 7'(n);
    gen_i = 2'(gen);

    k = 0;
    if (!exp_err) begin
      for (int i = 0; i < ucnt; i++) push(k, user_data_i[i*32 +: 32]);
      if (gid[0]) push(k, gid_x_i);
      if (gid[1]) push(k, gid_y_i);
      if (gid[2]) push(k, gid_z_i);
      if (sz)     push(k, wg_size_i);
      if (scr)    push(k, scratch_ofs_i);
    end

    start_i = 1'b1;
    @(posedge clk); #1;
    start_i = 1'b0;
    if (poke) begin
      @(posedge clk); #1;
      rsrc_i = '1; alloc_n_i = 7'd50; gen_i = 2'd0;
      start_i = 1'b1;                  // R10: must be ignored
      @(posedge clk); #1;
      start_i = 1'b0;
    end

    w = 0;
    do begin
      @(negedge clk);
      w++;
    end while (!done_o && w < 1000);

    chk(done_o, "R11", "done seen", 32'(done_o), 1);
    chk(q_idx.size() == 0, "R11", "writes left at done", 32'(q_idx.size()), 0);
    chk(alloc_err_o == exp_err, "R8 R9", "alloc_err", 32'(alloc_err_o), 32'(exp_err));
    chk(vcc_idx_o == 7'(n - 2), "R6 R10", "vcc idx", 32'(vcc_idx_o), 32'(n - 2));
    chk(flat_vld_o == (gen != 0), "R7", "flat vld", 32'(flat_vld_o), 32'(gen != 0));
    if (gen != 0)
      chk(flat_idx_o == 7'(n - 2 * pairs), "R7", "flat idx", 32'(flat_idx_o), 32'(n - 2 * pairs));
    chk(xnack_vld_o == (gen >= 2), "R7", "xnack vld", 32'(xnack_vld_o), 32'(gen >= 2));
    if (gen >= 2)
      chk(xnack_idx_o == 7'(n - 4), "R7", "xnack idx", 32'(xnack_idx_o), 32'(n - 4));
    @(negedge clk);
    chk(!done_o, "R11", "done one cycle", 32'(done_o), 0);
    chk(!wr_valid_o, "R10", "no write after done", 32'(wr_valid_o), 0);
    q_idx.delete();
    q_dat.delete();
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    chk(!wr_valid_o && !busy_o && !done_o && !alloc_err_o, "R11", "reset state",
        {28'b0, wr_valid_o, busy_o, done_o, alloc_err_o}, 0);

    run_case(4, 3'b111, 1, 1, 40, 2, 1, 0);    // R1 R2 R3 R7 newest
    stall_mode = 1'b1;
    run_case(3, 3'b010, 0, 1, 20, 1, 2, 1);    // R2 only Y, R5 stalls, R10 poke
    run_case(31, 3'b111, 1, 1, 38, 0, 3, 0);   // R9 exact fit, oldest gen
    run_case(31, 3'b111, 1, 1, 40, 2, 4, 0);   // R9 overlap error
    run_case(2, 3'b001, 0, 0, 103, 2, 5, 0);   // R8 over newest limit
    run_case(2, 3'b001, 0, 0, 104, 0, 6, 0);   // R8 at older limit
    run_case(2, 3'b001, 0, 0, 105, 1, 7, 0);   // R8 over older limit
    run_case(0, 3'b000, 0, 0, 10, 3, 8, 0);    // R11 empty, R7 gen 3
    run_case(1, 3'b101, 1, 0, 16, 1, 9, 0);    // R2 X and Z only, R3 size only
    stall_mode = 1'b0;
    run_case(6, 3'b100, 0, 1, 30, 0, 10, 1);   // R10 poke without stalls
    summary();
  end

endmodule